// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Window

This block lets a host read an external serial flash as if it were ordinary memory. Software first loads a phase configuration word, a flash base address and a window length while the window is closed. It then writes the control register with the open bit set, together with the device select and opcodes. From then on, each host read at byte offset `o` inside the window becomes one serial read transaction at flash address `base + o`. The transaction is handed to a separate serial engine, and the host read is held until the engine returns the data word.

Reads that fall outside the window, that would carry past the top of the 32-bit flash address space, or that arrive while the window is closed are answered at once with an error. They never reach the engine. The window is closed by writing the control register with the open bit clear. Closing waits for any transaction in flight to finish and for chip select to drop. The block then sets a sticky completion flag that software polls and clears by writing one to it.

Top module: `fwin_flash_window`

## Requirements
- R1: After reset, every register reads zero, `eng_cs` and `eng_start` are low, and `win_done` is low.
- R2: A control write (register index 0) with bit 31 set opens a closed window and latches device select in bits [22:21], the second opcode in bits [15:8] and the first opcode in bits [7:0]. Reading the control register returns those fields, and bit 31 reflects whether the window is open.
- R3: A host read at offset `o` in an open window gives exactly one `eng_start` pulse, with `eng_addr` = base + `o`, `eng_opcode` and `eng_opcode2` equal to the latched opcodes, and `eng_dev` equal to the latched device select.
- R4: `eng_cfg` is the configuration word (register index 1, 24 bits) with bit 23 (read) forced to 1, and with bit 11 (strobe enable) forced to 1 whenever bit 8 (double-rate data) is set.
- R5: `eng_cs` rises with `eng_start` and stays high until `eng_done`. The host read completes only after `eng_done`, with `win_rdata` equal to the engine's data and `win_err` = 0.
- R6: A read whose offset is at or above min(length register (index 3), APERTURE_BYTES) completes with `win_err` = 1 and `win_rdata` = 0, and starts no transaction.
- R7: A read for which base (register index 2) + offset exceeds 0xFFFF_FFFF completes with an error and starts no transaction.
- R8: A read while the window is closed completes with an error and starts no transaction.
- R9: While the window is open, writes to the configuration, base and length registers, and control writes with bit 31 set, have no effect.
- R10: A control write with bit 31 clear closes an open window. Status bit 11 (register index 4) is set, and control bit 31 clears, only once no transaction is in flight and `eng_cs` is low.
- R11: Writing 1 to status bit 11 clears it. Writing 0 to that bit leaves it set.
- R12: `win_done` is a single-cycle pulse for each host read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 3 | Register index (0 control, 1 config, 2 base, 3 length, 4 status) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data, combinational from `csr_addr` |
| win_req | input | 1 | Host read request, held until `win_done` |
| win_off | input | OFF_W | Byte offset of the host read within the window |
| win_done | output | 1 | Host read completion pulse |
| win_err | output | 1 | Error response, valid with `win_done` |
| win_rdata | output | 32 | Read data, valid with `win_done` |
| eng_start | output | 1 | One-cycle transaction launch to the serial engine |
| eng_cs | output | 1 | Chip select held for the whole transaction |
| eng_addr | output | 32 | Flash address of the transaction |
| eng_opcode | output | 8 | First opcode |
| eng_opcode2 | output | 8 | Second opcode |
| eng_dev | output | DEV_W | Target device select |
| eng_cfg | output | 24 | Phase configuration word for the transaction |
| eng_done | input | 1 | Engine data-return pulse |
| eng_rdata | input | 32 | Engine data word, valid with `eng_done` |

## Verification
The bound assertions check the following on every cycle:
- the launch is a single pulse covered by chip select;
- chip select is held until the engine answers;
- error completions never follow a live transaction;
- no launch happens while the window is closed;
- the close flag rises only once chip select has already dropped and the window has shut.

The directed scenarios cover the behaviour that only a known configuration can show:
- the exact translated address, opcodes, device and strobe-adjusted configuration;
- the range limit with the aperture cap, and the carry past the 32-bit address top;
- registers that stay frozen while the window is open;
- a close requested in the middle of a long transaction;
- write-one-to-clear on the status flag.

// File: rtl/fwin_pkg.sv
package fwin_pkg;

    localparam int CSR_AW = 3;
    localparam logic [CSR_AW-1:0] CSR_CTRL  = 3'd0;
    localparam logic [CSR_AW-1:0] CSR_OPCFG = 3'd1;
    localparam logic [CSR_AW-1:0] CSR_BASE  = 3'd2;
    localparam logic [CSR_AW-1:0] CSR_LEN   = 3'd3;
    localparam logic [CSR_AW-1:0] CSR_STAT  = 3'd4;

    localparam int OPEN_BIT  = 31;
    localparam int DEV_LSB   = 21;
    localparam int OP2_LSB   = 8;
    localparam int OP1_LSB   = 0;
    localparam int CLOSE_BIT = 11;

    localparam int CFG_W        = 24;
    localparam int CFG_READ_BIT = 23;
    localparam int CFG_DQS_BIT  = 11;
    localparam int CFG_DDR_BIT  = 8;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_ACK
    } seq_state_e;

    typedef struct packed {
        logic [31:0]      addr;
        logic [CFG_W-1:0] cfg;
    } launch_t;

    function automatic logic [CFG_W-1:0] window_cfg(input logic [CFG_W-1:0] c);
        logic [CFG_W-1:0] r;
        r = c;
        r[CFG_READ_BIT] = 1'b1;
        if (c[CFG_DDR_BIT]) r[CFG_DQS_BIT] = 1'b1;
        return r;
    endfunction

endpackage

// File: rtl/fwin_regs.sv
module fwin_regs
    import fwin_pkg::*;
#(
    parameter int DEV_W = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                csr_we,
    input  logic [CSR_AW-1:0]   csr_addr,
    input  logic [31:0]         csr_wdata,
    output logic [31:0]         csr_rdata,
    input  logic                seq_idle,
    output logic                win_en,
    output logic                win_live,
    output logic                close_flag,
    output logic [DEV_W-1:0]    dev,
    output logic [7:0]          op1,
    output logic [7:0]          op2,
    output logic [CFG_W-1:0]    cfg,
    output logic [31:0]         base,
    output logic [31:0]         len
);

    logic closing_q;
    logic wr_ctrl, wr_stat;
    logic [31:0] ctrl_view;

    assign wr_ctrl  = csr_we && (csr_addr == CSR_CTRL);
    assign wr_stat  = csr_we && (csr_addr == CSR_STAT);
    assign win_live = win_en && !closing_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_en     <= 1'b0;
            closing_q  <= 1'b0;
            close_flag <= 1'b0;
            dev        <= '0;
            op1        <= '0;
            op2        <= '0;
            cfg        <= '0;
            base       <= '0;
            len        <= '0;
        end else begin
            if (!win_en) begin
                if (csr_we && csr_addr == CSR_OPCFG) cfg  <= csr_wdata[CFG_W-1:0];
                if (csr_we && csr_addr == CSR_BASE)  base <= csr_wdata;
                if (csr_we && csr_addr == CSR_LEN)   len  <= csr_wdata;
                if (wr_ctrl && csr_wdata[OPEN_BIT]) begin
                    win_en <= 1'b1;
                    dev    <= csr_wdata[DEV_LSB +: DEV_W];
                    op2    <= csr_wdata[OP2_LSB +: 8];
                    op1    <= csr_wdata[OP1_LSB +: 8];
                end
            end else begin
                if (wr_ctrl && !csr_wdata[OPEN_BIT]) closing_q <= 1'b1;
                if (closing_q && seq_idle) begin
                    win_en    <= 1'b0;
                    closing_q <= 1'b0;
                end
            end
            if (win_en && closing_q && seq_idle)
                close_flag <= 1'b1;
            else if (wr_stat && csr_wdata[CLOSE_BIT])
                close_flag <= 1'b0;
        end
    end

    always_comb begin
        ctrl_view = '0;
        ctrl_view[OPEN_BIT]          = win_en;
        ctrl_view[DEV_LSB +: DEV_W]  = dev;
        ctrl_view[OP2_LSB +: 8]      = op2;
        ctrl_view[OP1_LSB +: 8]      = op1;
    end

    always_comb begin
        case (csr_addr)
            CSR_CTRL:  csr_rdata = ctrl_view;
            CSR_OPCFG: csr_rdata = {{(32-CFG_W){1'b0}}, cfg};
            CSR_BASE:  csr_rdata = base;
            CSR_LEN:   csr_rdata = len;
            CSR_STAT:  csr_rdata = {20'b0, close_flag, 11'b0};
            default:   csr_rdata = '0;
        endcase
    end

endmodule

// File: rtl/fwin_xlate.sv
module fwin_xlate #(
    parameter int OFF_W          = 16,
    parameter int APERTURE_BYTES = 4096
) (
    input  logic             win_live,
    input  logic [31:0]      base,
    input  logic [31:0]      len,
    input  logic [OFF_W-1:0] off,
    output logic             hit_ok,
    output logic [31:0]      flash_addr
);

    localparam logic [31:0] APERTURE = 32'(APERTURE_BYTES);

    logic [31:0] eff_len;
    logic [32:0] sum;

    always_comb begin
        eff_len    = (len > APERTURE) ? APERTURE : len;
        sum        = {1'b0, base} + {1'b0, 32'(off)};
        flash_addr = sum[31:0];
        hit_ok     = win_live && (32'(off) < eff_len) && !sum[32];
    end

endmodule

// File: rtl/fwin_seq.sv
module fwin_seq
    import fwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             win_req,
    input  logic             hit_ok,
    input  launch_t          launch_in,
    input  logic             eng_done,
    input  logic [31:0]      eng_rdata,
    output logic             seq_idle,
    output logic             win_done,
    output logic             win_err,
    output logic [31:0]      win_rdata,
    output logic             eng_start,
    output logic             eng_cs,
    output launch_t          launch_q
);

    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            win_err   <= 1'b0;
            win_rdata <= '0;
            launch_q  <= '0;
        end else begin
            case (state)
                SQ_IDLE: if (win_req) begin
                    if (hit_ok) begin
                        launch_q <= launch_in;
                        win_err  <= 1'b0;
                        state    <= SQ_LAUNCH;
                    end else begin
                        win_err   <= 1'b1;
                        win_rdata <= '0;
                        state     <= SQ_ACK;
                    end
                end
                SQ_LAUNCH: state <= SQ_WAIT;
                SQ_WAIT: if (eng_done) begin
                    win_rdata <= eng_rdata;
                    state     <= SQ_ACK;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign seq_idle  = (state == SQ_IDLE);
    assign win_done  = (state == SQ_ACK);
    assign eng_start = (state == SQ_LAUNCH);
    assign eng_cs    = (state == SQ_LAUNCH) || (state == SQ_WAIT);

endmodule

// File: rtl/fwin_flash_window.sv
module fwin_flash_window
    import fwin_pkg::*;
#(
    parameter int OFF_W          = 16,
    parameter int APERTURE_BYTES = 4096,
    parameter int DEV_W          = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               csr_we,
    input  logic [2:0]         csr_addr,
    input  logic [31:0]        csr_wdata,
    output logic [31:0]        csr_rdata,
    input  logic               win_req,
    input  logic [OFF_W-1:0]   win_off,
    output logic               win_done,
    output logic               win_err,
    output logic [31:0]        win_rdata,
    output logic               eng_start,
    output logic               eng_cs,
    output logic [31:0]        eng_addr,
    output logic [7:0]         eng_opcode,
    output logic [7:0]         eng_opcode2,
    output logic [DEV_W-1:0]   eng_dev,
    output logic [23:0]        eng_cfg,
    input  logic               eng_done,
    input  logic [31:0]        eng_rdata
);

    logic             seq_idle, win_en, win_live, close_flag, hit_ok;
    logic [CFG_W-1:0] cfg;
    logic [31:0]      base, len, flash_addr;
    launch_t          launch_in, launch_q;

    fwin_regs #(.DEV_W(DEV_W)) u_regs (
        .clk(clk), .rst(rst),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .seq_idle(seq_idle),
        .win_en(win_en), .win_live(win_live), .close_flag(close_flag),
        .dev(eng_dev), .op1(eng_opcode), .op2(eng_opcode2),
        .cfg(cfg), .base(base), .len(len)
    );

    fwin_xlate #(.OFF_W(OFF_W), .APERTURE_BYTES(APERTURE_BYTES)) u_xlate (
        .win_live(win_live), .base(base), .len(len), .off(win_off),
        .hit_ok(hit_ok), .flash_addr(flash_addr)
    );

    assign launch_in.addr = flash_addr;
    assign launch_in.cfg  = window_cfg(cfg);

    fwin_seq u_seq (
        .clk(clk), .rst(rst),
        .win_req(win_req), .hit_ok(hit_ok), .launch_in(launch_in),
        .eng_done(eng_done), .eng_rdata(eng_rdata),
        .seq_idle(seq_idle), .win_done(win_done), .win_err(win_err),
        .win_rdata(win_rdata), .eng_start(eng_start), .eng_cs(eng_cs),
        .launch_q(launch_q)
    );

    assign eng_addr = launch_q.addr;
    assign eng_cfg  = launch_q.cfg;

endmodule

// File: rtl/fwin_flash_window_chk.sv
module fwin_flash_window_chk (
    input logic clk,
    input logic rst,
    input logic eng_start,
    input logic eng_cs,
    input logic eng_done,
    input logic win_done,
    input logic win_err,
    input logic win_en,
    input logic close_flag
);

    a_r5_start_pulse: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    a_r5_cs_covers_start: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> eng_cs);

    a_r5_cs_held: assert property (@(posedge clk) disable iff (rst)
        (eng_cs && !eng_done) |=> eng_cs);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (rst)
        win_done |=> !win_done);

    a_r6_err_no_launch: assert property (@(posedge clk) disable iff (rst)
        (win_done && win_err) |-> !$past(eng_cs));

    a_r8_launch_needs_open: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> win_en);

    a_r10_flag_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(close_flag) |-> (!$past(eng_cs) && !win_en));

endmodule

bind fwin_flash_window fwin_flash_window_chk u_chk (
    .clk(clk), .rst(rst), .eng_start(eng_start), .eng_cs(eng_cs),
    .eng_done(eng_done), .win_done(win_done), .win_err(win_err),
    .win_en(win_en), .close_flag(close_flag)
);

// File: tb/fwin_flash_window_tb.sv
`timescale 1ns/1ps
module fwin_flash_window_tb;

    localparam int OFF_W = 16;
    localparam logic [31:0] KEY = 32'h5A5A_0F0F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic csr_we = 1'b0;
    logic [2:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;
    logic win_req = 1'b0;
    logic [OFF_W-1:0] win_off = '0;
    logic win_done, win_err;
    logic [31:0] win_rdata;
    logic eng_start, eng_cs;
    logic [31:0] eng_addr;
    logic [7:0] eng_opcode, eng_opcode2;
    logic [1:0] eng_dev;
    logic [23:0] eng_cfg;
    logic eng_done = 1'b0;
    logic [31:0] eng_rdata = '0;

    int checks = 0;
    int errors = 0;

    int lat = 3;
    int cnt = 0;
    logic busy = 1'b0;
    int n_starts = 0;
    logic [31:0] cap_addr = '0;
    logic [7:0] cap_op1 = '0, cap_op2 = '0;
    logic [1:0] cap_dev = '0;
    logic [23:0] cap_cfg = '0;

    always #2 clk = ~clk;

    fwin_flash_window u_dut (
        .clk(clk), .rst(rst),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata),
        .win_req(win_req), .win_off(win_off), .win_done(win_done),
        .win_err(win_err), .win_rdata(win_rdata),
        .eng_start(eng_start), .eng_cs(eng_cs), .eng_addr(eng_addr),
        .eng_opcode(eng_opcode), .eng_opcode2(eng_opcode2),
        .eng_dev(eng_dev), .eng_cfg(eng_cfg),
        .eng_done(eng_done), .eng_rdata(eng_rdata)
    );

    // serial engine model
    always @(posedge clk) begin
        eng_done <= 1'b0;
        if (rst) begin
            busy <= 1'b0;
        end else if (eng_start) begin
            busy     <= 1'b1;
            cnt      <= lat;
            n_starts <= n_starts + 1;
            cap_addr <= eng_addr;
            cap_op1  <= eng_opcode;
            cap_op2  <= eng_opcode2;
            cap_dev  <= eng_dev;
            cap_cfg  <= eng_cfg;
        end else if (busy) begin
            if (cnt <= 1) begin
                eng_done  <= 1'b1;
                eng_rdata <= cap_addr ^ KEY;
                busy      <= 1'b0;
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic csr_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        csr_addr = a;
        #1 d = csr_rdata;
    endtask

    task automatic host_read(input logic [OFF_W-1:0] off, output logic err, output logic [31:0] data);
        int guard;
        @(negedge clk);
        win_req = 1'b1; win_off = off;
        guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!win_done && guard < 1000);
        err = win_err; data = win_rdata;
        win_req = 1'b0;
        @(negedge clk);
        check("R12 done pulse width", 32'(win_done), 32'd0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) begin
            csr_read(3'(i), d);
            check("R1 register reset value", d, 32'h0);
        end
        check("R1 cs idle", 32'(eng_cs), 32'd0);
        check("R1 start idle", 32'(eng_start), 32'd0);
        check("R1 done idle", 32'(win_done), 32'd0);
    endtask

    task automatic t_closed_read(input string tag);
        logic e; logic [31:0] d; int s0;
        s0 = n_starts;
        host_read(16'h0004, e, d);
        check({tag, " closed read error"}, 32'(e), 32'd1);
        check({tag, " closed read data"}, d, 32'h0);
        check({tag, " closed read no launch"}, 32'(n_starts), 32'(s0));
    endtask

    task automatic t_arm();
        logic [31:0] d;
        csr_write(3'd1, 32'h0000_0100);
        csr_write(3'd2, 32'h1000_0000);
        csr_write(3'd3, 32'h0000_2000);
        csr_write(3'd0, 32'h8040_5AEB);
        csr_read(3'd0, d);
        check("R2 control readback", d, 32'h8040_5AEB);
    endtask

    task automatic t_translate(input logic [OFF_W-1:0] off);
        logic e; logic [31:0] d; int s0;
        s0 = n_starts;
        host_read(off, e, d);
        check("R5 no error", 32'(e), 32'd0);
        check("R3 one launch", 32'(n_starts), 32'(s0 + 1));
        check("R3 flash address", cap_addr, 32'h1000_0000 + 32'(off));
        check("R3 first opcode", 32'(cap_op1), 32'h0000_00EB);
        check("R3 second opcode", 32'(cap_op2), 32'h0000_005A);
        check("R3 device", 32'(cap_dev), 32'd2);
        check("R4 cfg with strobe", 32'(cap_cfg), 32'h0080_0900);
        check("R5 data returned", d, (32'h1000_0000 + 32'(off)) ^ KEY);
    endtask

    task automatic t_range();
        logic e; logic [31:0] d; int s0;
        s0 = n_starts;
        host_read(16'h0FFF, e, d);
        check("R6 last aperture byte accepted", 32'(e), 32'd0);
        s0 = n_starts;
        host_read(16'h1000, e, d);
        check("R6 aperture cap error", 32'(e), 32'd1);
        check("R6 aperture cap no launch", 32'(n_starts), 32'(s0));
    endtask

    task automatic t_frozen();
        logic e; logic [31:0] d;
        csr_write(3'd2, 32'h2222_0000);
        csr_write(3'd1, 32'h0000_0005);
        csr_write(3'd0, 32'h8000_0011);
        csr_read(3'd0, d);
        check("R9 control frozen", d, 32'h8040_5AEB);
        csr_read(3'd2, d);
        check("R9 base frozen", d, 32'h1000_0000);
        host_read(16'h0004, e, d);
        check("R9 address uses old base", cap_addr, 32'h1000_0004);
        check("R9 opcode unchanged", 32'(cap_op1), 32'h0000_00EB);
        check("R9 cfg unchanged", 32'(cap_cfg), 32'h0080_0900);
    endtask

    task automatic t_close_idle();
        logic [31:0] d;
        csr_write(3'd0, 32'h0000_0000);
        repeat (2) @(negedge clk);
        csr_read(3'd4, d);
        check("R10 close flag set", d, 32'h0000_0800);
        csr_read(3'd0, d);
        check("R10 window closed", d & 32'h8000_0000, 32'h0);
        csr_write(3'd4, 32'h0000_0000);
        csr_read(3'd4, d);
        check("R11 write zero keeps flag", d, 32'h0000_0800);
        csr_write(3'd4, 32'h0000_0800);
        csr_read(3'd4, d);
        check("R11 write one clears flag", d, 32'h0);
    endtask

    task automatic t_overflow();
        logic e; logic [31:0] d; int s0;
        csr_write(3'd1, 32'h0000_0005);
        csr_write(3'd2, 32'hFFFF_FFF0);
        csr_write(3'd3, 32'h0000_0100);
        csr_write(3'd0, 32'h8020_0103);
        host_read(16'h000F, e, d);
        check("R7 top address accepted", 32'(e), 32'd0);
        check("R7 top address", cap_addr, 32'hFFFF_FFFF);
        check("R4 cfg without strobe", 32'(cap_cfg), 32'h0080_0005);
        s0 = n_starts;
        host_read(16'h0010, e, d);
        check("R7 carry error", 32'(e), 32'd1);
        check("R7 carry no launch", 32'(n_starts), 32'(s0));
        s0 = n_starts;
        host_read(16'h0100, e, d);
        check("R6 length limit error", 32'(e), 32'd1);
        check("R6 length limit no launch", 32'(n_starts), 32'(s0));
    endtask

    task automatic t_close_inflight();
        logic e; logic [31:0] d, st;
        lat = 20;
        fork
            host_read(16'h0008, e, d);
            begin
                repeat (4) @(negedge clk);
                csr_write(3'd0, 32'h0000_0000);
                repeat (2) @(negedge clk);
                check("R5 cs held during fetch", 32'(eng_cs), 32'd1);
                csr_read(3'd4, st);
                check("R10 flag waits for transaction", st, 32'h0);
            end
        join
        check("R5 inflight read completed", 32'(e), 32'd0);
        check("R5 inflight data", d, (32'hFFFF_FFF0 + 32'h8) ^ KEY);
        repeat (3) @(negedge clk);
        csr_read(3'd4, st);
        check("R10 flag after release", st, 32'h0000_0800);
        csr_read(3'd0, st);
        check("R10 closed after release", st & 32'h8000_0000, 32'h0);
        lat = 3;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_closed_read("R8");
        t_arm();
        t_translate(16'h0000);
        t_translate(16'h0024);
        t_translate(16'h1FFF & 16'h00FF);
        t_range();
        t_frozen();
        t_close_idle();
        t_closed_read("R8 after close");
        t_overflow();
        t_close_inflight();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule